// File: doc/BRIEF.md
# Quad Clocked Programmable Tap Delay

This block delays four independent single-bit signals by a programmable number of system clock cycles. Each channel feeds its input through a fixed lag stage of `BASE_CYCLES` registers and then into a chain of fifteen equal segments, each `STEP_CYCLES` registers long. A 4-bit tap address per channel picks which segment boundary drives that channel's registered output. The delay is therefore `BASE_CYCLES + addr * STEP_CYCLES` cycles, giving sixteen settings. Address zero taps the lag stage directly and gives the inherent delay alone.

Each channel also holds an enable flag. A low enable drops the channel's output-enable flag and forces its data output to zero. This stands in for a high-impedance pad. Tap addresses and enables are captured from a configuration bus on a one-cycle load strobe and are used from the following clock edge.

Switching a tap does not flush the chain, so the output jumps to whatever history sits at the new tap. To avoid stray edges, a user holds the input still for at least the longest programmable delay before reprogramming. The input is a plain sampled level, with no handshake: every cycle carries a sample, so there is no back-pressure.

Top module: `quad_tap_delay`

## Requirements
- R1: While `rst` is high at a clock edge, every chain register, tap address, enable, `dout` bit and `dout_oe` bit is cleared, so after reset both outputs read 0.
- R2: For an enabled channel c with address a, a `din[c]` value sampled at edge e appears non-inverted on `dout[c]` just after edge e + BASE_CYCLES + a*STEP_CYCLES. Rising and falling edges are delayed alike, so pulse widths are preserved.
- R3: Tap address 0 gives the minimum delay of exactly BASE_CYCLES edges.
- R4: Tap address 15 gives the maximum delay of BASE_CYCLES + 15*STEP_CYCLES edges.
- R5: Channel c takes its address from `cfg_addr[4c+3:4c]` and its enable from `cfg_en[c]`. Each channel's delay depends only on its own field and input.
- R6: While a channel's stored enable is 0, its `dout_oe` bit is 0 and its `dout` bit is 0, whatever its input does.
- R7: When `cfg_load` is low, changes on `cfg_addr` and `cfg_en` have no effect on either output.
- R8: A load at edge e makes the new address and enable govern `dout` and `dout_oe` from edge e+1 onward. Chain contents are kept across the change.
- R9: If `rst` and `cfg_load` are both high at an edge, reset wins: all channels come out disabled with address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 4 | One input sample per channel per cycle |
| cfg_load | input | 1 | One-cycle strobe that captures address and enable values |
| cfg_addr | input | 16 | Tap addresses, channel c in bits 4c+3..4c |
| cfg_en | input | 4 | Channel enables, bit c for channel c |
| dout | output | 4 | Registered delayed copy per channel, 0 when disabled |
| dout_oe | output | 4 | Registered output-enable flag per channel |

## Verification
The interesting collision is a load strobe landing while edges are still travelling through a chain. The new tap then reads history that was captured under the old setting. The bench toggles inputs continuously and fires loads in the middle of the stream. It judges every cycle against a cycle-indexed record of the sampled inputs, so the jump to the new tap must land exactly one edge after the strobe. A second collision, reset asserted together with a load, must leave every channel disabled.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
  localparam int NUM_CH    = 4;
  localparam int ADDR_W    = 4;
  localparam int NUM_STEPS = (1 << ADDR_W) - 1;

  typedef struct packed {
    logic              en;
    logic [ADDR_W-1:0] addr;
  } ch_cfg_t;
endpackage

// File: rtl/qtd_cfg_bank.sv
module qtd_cfg_bank
  import qtd_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [NUM_CH*ADDR_W-1:0] addr_bus,
  input  logic [NUM_CH-1:0]        en_bus,
  output ch_cfg_t [NUM_CH-1:0]     cfg_q
);
  // Per-channel setting registers; reset has priority over a load.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[c] <= '0;
      end else if (load) begin
        cfg_q[c].addr <= addr_bus[c*ADDR_W +: ADDR_W];
        cfg_q[c].en   <= en_bus[c];
      end
    end
  end
endmodule

// File: rtl/qtd_lag_stage.sv
module qtd_lag_stage #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  // Fixed inherent latency; zero makes the stage a wire.
  if (LAG == 0) begin : g_wire
    assign q = d;
  end else if (LAG == 1) begin : g_one
    logic r;
    always_ff @(posedge clk) begin
      if (rst) r <= 1'b0;
      else     r <= d;
    end
    assign q = r;
  end else begin : g_multi
    logic [LAG-1:0] r;
    always_ff @(posedge clk) begin
      if (rst) r <= '0;
      else     r <= {r[LAG-2:0], d};
    end
    assign q = r[LAG-1];
  end
endmodule

// File: rtl/qtd_tap_line.sv
module qtd_tap_line
  import qtd_pkg::*;
#(
  parameter int STEP_CYCLES = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    d,
  input  ch_cfg_t cfg,
  output logic    q,
  output logic    oe
);
  localparam int CHAIN_LEN = NUM_STEPS * STEP_CYCLES;

  logic [CHAIN_LEN:1] sr;
  logic [NUM_STEPS:0] taps;
  logic               pick;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[CHAIN_LEN-1:1], d};
  end

  // Tap 0 is the line input; tap t sits at the end of segment t.
  assign taps[0] = d;
  for (genvar t = 1; t <= NUM_STEPS; t++) begin : g_tap
    assign taps[t] = sr[t*STEP_CYCLES];
  end

  assign pick = taps[cfg.addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      q  <= 1'b0;
      oe <= 1'b0;
    end else begin
      q  <= cfg.en & pick;
      oe <= cfg.en;
    end
  end
endmodule

// File: rtl/quad_tap_delay.sv
module quad_tap_delay
  import qtd_pkg::*;
#(
  parameter int BASE_CYCLES = 2,
  parameter int STEP_CYCLES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        din,
  input  logic                     cfg_load,
  input  logic [NUM_CH*ADDR_W-1:0] cfg_addr,
  input  logic [NUM_CH-1:0]        cfg_en,
  output logic [NUM_CH-1:0]        dout,
  output logic [NUM_CH-1:0]        dout_oe
);
  ch_cfg_t [NUM_CH-1:0] cfg_q;

  qtd_cfg_bank i_cfg (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .addr_bus (cfg_addr),
    .en_bus   (cfg_en),
    .cfg_q    (cfg_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_line
    logic lagged;

    qtd_lag_stage #(.LAG(BASE_CYCLES)) i_lag (
      .clk (clk),
      .rst (rst),
      .d   (din[c]),
      .q   (lagged)
    );

    qtd_tap_line #(.STEP_CYCLES(STEP_CYCLES)) i_tap (
      .clk (clk),
      .rst (rst),
      .d   (lagged),
      .cfg (cfg_q[c]),
      .q   (dout[c]),
      .oe  (dout_oe[c])
    );
  end
endmodule

// File: rtl/qtd_checker.sv
module qtd_checker
  import qtd_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic [NUM_CH-1:0] cfg_en,
  input logic [NUM_CH-1:0] dout,
  input logic [NUM_CH-1:0] dout_oe
);
  // R1: an edge under reset leaves both outputs cleared.
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (dout == '0 && dout_oe == '0));

  // R6: a disabled channel never drives a one.
  p_dis_low_r6: assert property (@(posedge clk) disable iff (rst)
    ((dout & ~dout_oe) == '0));

  // R7: without a strobe the enable flags hold.
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_load ##1 1'b1) |=> $stable(dout_oe));

  // R8: a strobe's enables reach the flags one edge later.
  p_apply_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_load ##1 1'b1) |=> (dout_oe == $past(cfg_en, 2)));

  // R9: reset beats a concurrent load, so flags stay low one edge on.
  p_reset_wins_r9: assert property (@(posedge clk)
    rst |-> ##2 (dout_oe == '0));
endmodule

bind quad_tap_delay qtd_checker i_qtd_checker (
  .clk      (clk),
  .rst      (rst),
  .cfg_load (cfg_load),
  .cfg_en   (cfg_en),
  .dout     (dout),
  .dout_oe  (dout_oe)
);

// File: tb/test_quad_tap_delay.sv
module test_quad_tap_delay;
  localparam int BASE = 2;
  localparam int STEP = 3;
  localparam int NCH  = 4;
  localparam int HLEN = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NCH-1:0]   din = '0;
  logic             cfg_load = 1'b0;
  logic [NCH*4-1:0] cfg_addr = '0;
  logic [NCH-1:0]   cfg_en = '0;
  logic [NCH-1:0]   dout;
  logic [NCH-1:0]   dout_oe;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  quad_tap_delay #(.BASE_CYCLES(BASE), .STEP_CYCLES(STEP)) i_quad_tap_delay (
    .clk(clk), .rst(rst), .din(din), .cfg_load(cfg_load),
    .cfg_addr(cfg_addr), .cfg_en(cfg_en), .dout(dout), .dout_oe(dout_oe)
  );

  // Requirement model: record sampled inputs per edge, delay by settings.
  logic [NCH-1:0] hist [HLEN];
  int             cyc = 0;
  logic [3:0]     m_addr [NCH];
  logic [NCH-1:0] m_en = '0;
  logic [NCH-1:0] exp_dout = '0;
  logic [NCH-1:0] exp_oe = '0;

  always @(posedge clk) begin
    if (rst) begin
      cyc = 0;
      m_en = '0;
      for (int c = 0; c < NCH; c++) m_addr[c] = 4'd0;
      exp_dout = '0;
      exp_oe = '0;
    end else begin
      hist[cyc % HLEN] = din;
      for (int c = 0; c < NCH; c++) begin
        int k;
        k = cyc - (BASE + int'(m_addr[c]) * STEP);
        exp_dout[c] = m_en[c] & ((k < 0) ? 1'b0 : hist[k % HLEN][c]);
      end
      exp_oe = m_en;
      if (cfg_load) begin
        m_en = cfg_en;
        for (int c = 0; c < NCH; c++) m_addr[c] = cfg_addr[c*4 +: 4];
      end
      cyc++;
    end
  end

  task automatic check(input string req, input logic [NCH-1:0] act,
                       input logic [NCH-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at t=%0t", req, act, exp, $time);
    end
  endtask

  // Sample after the edge, then drive for the next one.
  task automatic step_cycle(input string req);
    @(negedge clk);
    check({req, " dout"}, dout, exp_dout);
    check({req, " dout_oe"}, dout_oe, exp_oe);
  endtask

  task automatic load_cfg(input logic [15:0] a, input logic [3:0] e);
    cfg_addr = a; cfg_en = e; cfg_load = 1'b1;
    step_cycle("R8 load");
    cfg_load = 1'b0;
  endtask

  task automatic t_reset_r1();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 dout after reset", dout, '0);
    check("R1 dout_oe after reset", dout_oe, '0);
  endtask

  // Single pulse per channel to pin exact latency of address 0 and 15.
  task automatic t_pulse_r3_r4();
    int t0;
    int seen0;
    int seen2;
    load_cfg(16'h0_F_0_0, 4'b0101);
    repeat (60) step_cycle("R3 settle");
    din = 4'b0101;
    t0 = cyc;
    step_cycle("R2 pulse");
    din = 4'b0000;
    seen0 = -1; seen2 = -1;
    for (int i = 0; i < 60; i++) begin
      step_cycle("R4 pulse");
      if (dout[0] && seen0 < 0) seen0 = cyc - 1 - t0;
      if (dout[2] && seen2 < 0) seen2 = cyc - 1 - t0;
    end
    checks++;
    if (seen0 != BASE) begin
      fails++; $display("FAIL R3: actual %0d expected %0d", seen0, BASE);
    end
    checks++;
    if (seen2 != BASE + 15*STEP) begin
      fails++; $display("FAIL R4: actual %0d expected %0d", seen2, BASE + 15*STEP);
    end
  endtask

  task automatic t_stream_r2_r5();
    logic [7:0] lfsr = 8'h5A;
    load_cfg(16'h9_F_5_0, 4'b1111);
    for (int i = 0; i < 150; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      din = lfsr[3:0];
      step_cycle("R2 R5 stream");
    end
  endtask

  task automatic t_disable_r6();
    load_cfg(16'h9_F_5_0, 4'b1101);
    for (int i = 0; i < 40; i++) begin
      din = (i % 2) ? 4'b1111 : 4'b0010;
      step_cycle("R6 disabled");
      if (dout[1] !== 1'b0 || dout_oe[1] !== 1'b0 && i > 0) begin
        checks++; fails++;
        $display("FAIL R6: actual %b/%b expected 0/0", dout[1], dout_oe[1]);
      end
    end
  endtask

  task automatic t_ignore_r7();
    cfg_addr = 16'h1_2_3_4; cfg_en = 4'b0000;
    for (int i = 0; i < 60; i++) begin
      din = (i % 3 == 0) ? 4'b1011 : 4'b0100;
      step_cycle("R7 no strobe");
    end
  endtask

  task automatic t_midstream_r8();
    for (int j = 0; j < 4; j++) begin
      for (int i = 0; i < 20; i++) begin
        din = ((i + j) % 4 < 2) ? 4'b1111 : 4'b0000;
        step_cycle("R8 stream");
      end
      din = ~din;
      load_cfg({4'(j+3), 4'(15-j), 4'(2*j), 4'(j)}, 4'b1111);
    end
    repeat (60) step_cycle("R8 drain");
  endtask

  task automatic t_reset_load_r9();
    cfg_addr = 16'hFFFF; cfg_en = 4'b1111; cfg_load = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    rst = 1'b0;
    din = 4'b1111;
    @(negedge clk);
    check("R9 oe after reset+load", dout_oe, '0);
    check("R9 dout after reset+load", dout, '0);
    repeat (10) step_cycle("R9 after");
  endtask

  initial begin
    #(20 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_r1();
    t_pulse_r3_r4();
    t_stream_r2_r5();
    t_disable_r6();
    t_ignore_r7();
    t_midstream_r8();
    t_reset_load_r9();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule